// File: doc/BRIEF.md
# CPU Control Registers: Program Counter and Status Word

This block holds the sequencing state of a small 8-bit processor. It contains a 16-bit program counter and an 8-bit status word that carries interrupt enable, zero, auxiliary carry, carry, in-service priority and a 2-bit register bank number. An external sequencer drives it with one-cycle commands. These commands load the reset vector, branch, advance by the instruction length, restore the status word from a popped byte, acknowledge an interrupt, enable or disable interrupts, select a bank, and write back ALU flags.

The status word is always visible on `psw_o`. The stack logic can push it on interrupt entry or on a push instruction. The selected bank drives the register-file address through `bank_o`. When several commands that write the status word arrive in one cycle, a fixed priority picks exactly one of them to take effect.

Top module: `cpu_ctrl_regs`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0000h and `psw_o` is 02h, with only ISP (bit 1) set.
- R2: `vec_load_i` loads `pc_o` with `{vec_hi_i, vec_lo_i}` and `psw_o` with 02h on the next edge. It overrides every other command.
- R3: `br_i` loads `pc_o` with `br_tgt_i` on the next edge and overrides `adv_i`.
- R4: `adv_i` adds `ilen_i` to `pc_o`, modulo 2^16.
- R5: `pop_i` loads `psw_o` from `pop_data_i` with bit 2 forced to 0. Among status-word commands it ranks just below vector load.
- R6: `irq_ack_i` clears only IE (bit 7). It ranks below pop and above the explicit flag commands and the ALU update, which are ignored in that cycle.
- R7: `ei_i` sets IE and `di_i` clears it, and `di_i` wins when both are high. Explicit flag commands (`ei_i`, `di_i`, `sel_bank_i`) take effect together and override an ALU update in the same cycle.
- R8: `sel_bank_i` writes `bank_i[1]` to bit 5 and `bank_i[0]` to bit 3. `bank_o` always shows `{psw_o[5], psw_o[3]}`.
- R9: `alu_we_i` writes Z (bit 6) from `alu_zero_i`, AC (bit 4) from `alu_ac_i` and CY (bit 0) from `alu_cy_i`, and leaves the other bits unchanged.
- R10: Bit 2 of `psw_o` always reads 0. With no command active, `pc_o` and `psw_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_load_i | input | 1 | Load reset vector and reset the status word |
| vec_lo_i | input | 8 | Vector byte read from address 0000h |
| vec_hi_i | input | 8 | Vector byte read from address 0001h |
| br_i | input | 1 | Branch command |
| br_tgt_i | input | 16 | Branch target |
| adv_i | input | 1 | Advance PC by instruction length |
| ilen_i | input | 3 | Fetched instruction byte count |
| pop_i | input | 1 | Restore status word (return or pop) |
| pop_data_i | input | 8 | Byte popped from the stack |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| ei_i | input | 1 | Enable interrupts |
| di_i | input | 1 | Disable interrupts |
| sel_bank_i | input | 1 | Register bank select command |
| bank_i | input | 2 | Bank number to select |
| alu_we_i | input | 1 | ALU flag write-back |
| alu_zero_i | input | 1 | ALU result was zero |
| alu_ac_i | input | 1 | ALU auxiliary carry |
| alu_cy_i | input | 1 | ALU carry |
| pc_o | output | 16 | Program counter |
| psw_o | output | 8 | Status word, for pushing onto the stack |
| bank_o | output | 2 | Selected register bank |

## Verification
The assertions check the following on every cycle:
- the reserved bit stays at 0;
- a vector load, branch, advance or pop yields the expected next value;
- an acknowledge clears only IE when nothing of higher rank is present;
- a bank select sets `bank_o`;
- idle cycles hold state.

The bench scenarios are needed for the rest. They sweep every popped byte, every bank, every ALU flag combination and every instruction length. They also cover PC wrap at FFFFh, the EI/DI conflict, and the full priority ladder with all commands raised together. Only these scenarios show that lower-ranked commands are really dropped.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;
  localparam int PSW_W    = 8;
  localparam int PSW_IE   = 7;
  localparam int PSW_Z    = 6;
  localparam int PSW_RBS1 = 5;
  localparam int PSW_AC   = 4;
  localparam int PSW_RBS0 = 3;
  localparam int PSW_RSV  = 2;
  localparam int PSW_ISP  = 1;
  localparam int PSW_CY   = 0;
  localparam logic [PSW_W-1:0] PSW_RST = 8'h02;

  typedef enum logic [2:0] {
    PSW_HOLD, PSW_VEC, PSW_POP, PSW_ACK, PSW_EXPL, PSW_ALU
  } psw_sel_e;
endpackage

// File: rtl/cpu_pc_unit.sv
module cpu_pc_unit #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_load_i,
  input  logic [7:0]       vec_lo_i,
  input  logic [7:0]       vec_hi_i,
  input  logic             br_i,
  input  logic [PC_W-1:0]  br_tgt_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] ilen_i,
  output logic [PC_W-1:0]  pc_o
);
  localparam int VEC_W = 16;

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [VEC_W-1:0] vec_word;

  assign vec_word = {vec_hi_i, vec_lo_i};

  always_comb begin
    pc_d = pc_q;
    if (vec_load_i)  pc_d = PC_W'(vec_word);
    else if (br_i)   pc_d = br_tgt_i;
    else if (adv_i)  pc_d = pc_q + PC_W'(ilen_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/cpu_psw_arb.sv
module cpu_psw_arb
  import cpu_ctrl_pkg::*;
(
  input  logic     vec_load_i,
  input  logic     pop_i,
  input  logic     irq_ack_i,
  input  logic     ei_i,
  input  logic     di_i,
  input  logic     sel_bank_i,
  input  logic     alu_we_i,
  output psw_sel_e sel_o
);
  always_comb begin
    if (vec_load_i)                    sel_o = PSW_VEC;
    else if (pop_i)                    sel_o = PSW_POP;
    else if (irq_ack_i)                sel_o = PSW_ACK;
    else if (ei_i || di_i || sel_bank_i) sel_o = PSW_EXPL;
    else if (alu_we_i)                 sel_o = PSW_ALU;
    else                               sel_o = PSW_HOLD;
  end
endmodule

// File: rtl/cpu_psw_unit.sv
module cpu_psw_unit
  import cpu_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  psw_sel_e         sel_i,
  input  logic [PSW_W-1:0] pop_data_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             sel_bank_i,
  input  logic [1:0]       bank_i,
  input  logic             alu_zero_i,
  input  logic             alu_ac_i,
  input  logic             alu_cy_i,
  output logic [PSW_W-1:0] psw_o
);
  logic [PSW_W-1:0] psw_q, psw_d;

  always_comb begin
    psw_d = psw_q;
    unique case (sel_i)
      PSW_VEC: psw_d = PSW_RST;
      PSW_POP: psw_d = pop_data_i;
      PSW_ACK: psw_d[PSW_IE] = 1'b0;
      PSW_EXPL: begin
        if (di_i)      psw_d[PSW_IE] = 1'b0;
        else if (ei_i) psw_d[PSW_IE] = 1'b1;
        if (sel_bank_i) begin
          psw_d[PSW_RBS1] = bank_i[1];
          psw_d[PSW_RBS0] = bank_i[0];
        end
      end
      PSW_ALU: begin
        psw_d[PSW_Z]  = alu_zero_i;
        psw_d[PSW_AC] = alu_ac_i;
        psw_d[PSW_CY] = alu_cy_i;
      end
      default: psw_d = psw_q;
    endcase
    psw_d[PSW_RSV] = 1'b0;  // reserved bit never stores a 1
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psw_q <= PSW_RST;
    else         psw_q <= psw_d;
  end

  assign psw_o = psw_q;
endmodule

// File: rtl/cpu_ctrl_regs.sv
module cpu_ctrl_regs
  import cpu_ctrl_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_load_i,
  input  logic [7:0]       vec_lo_i,
  input  logic [7:0]       vec_hi_i,
  input  logic             br_i,
  input  logic [PC_W-1:0]  br_tgt_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] ilen_i,
  input  logic             pop_i,
  input  logic [7:0]       pop_data_i,
  input  logic             irq_ack_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             sel_bank_i,
  input  logic [1:0]       bank_i,
  input  logic             alu_we_i,
  input  logic             alu_zero_i,
  input  logic             alu_ac_i,
  input  logic             alu_cy_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [7:0]       psw_o,
  output logic [1:0]       bank_o
);
  psw_sel_e psw_sel;

  cpu_pc_unit #(.PC_W(PC_W), .LEN_W(LEN_W)) pc_i (
    .clk_i, .rst_ni, .vec_load_i, .vec_lo_i, .vec_hi_i,
    .br_i, .br_tgt_i, .adv_i, .ilen_i, .pc_o
  );

  cpu_psw_arb arb_i (
    .vec_load_i, .pop_i, .irq_ack_i, .ei_i, .di_i, .sel_bank_i, .alu_we_i,
    .sel_o(psw_sel)
  );

  cpu_psw_unit psw_i (
    .clk_i, .rst_ni, .sel_i(psw_sel), .pop_data_i, .ei_i, .di_i,
    .sel_bank_i, .bank_i, .alu_zero_i, .alu_ac_i, .alu_cy_i, .psw_o
  );

  assign bank_o = {psw_o[PSW_RBS1], psw_o[PSW_RBS0]};
endmodule

// File: rtl/cpu_ctrl_regs_chk.sv
module cpu_ctrl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        vec_load_i,
  input logic [7:0]  vec_lo_i,
  input logic [7:0]  vec_hi_i,
  input logic        br_i,
  input logic [15:0] br_tgt_i,
  input logic        adv_i,
  input logic [2:0]  ilen_i,
  input logic        pop_i,
  input logic [7:0]  pop_data_i,
  input logic        irq_ack_i,
  input logic        ei_i,
  input logic        di_i,
  input logic        sel_bank_i,
  input logic [1:0]  bank_i,
  input logic        alu_we_i,
  input logic [15:0] pc_o,
  input logic [7:0]  psw_o,
  input logic [1:0]  bank_o
);
  logic idle;
  assign idle = !(vec_load_i || br_i || adv_i || pop_i || irq_ack_i ||
                  ei_i || di_i || sel_bank_i || alu_we_i);

  a_r2_vec_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_i |=> pc_o == {$past(vec_hi_i), $past(vec_lo_i)});
  a_r2_vec_psw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_i |=> psw_o == 8'h02);
  a_r3_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !vec_load_i) |=> pc_o == $past(br_tgt_i));
  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !br_i && !vec_load_i) |=> pc_o == $past(pc_o) + 16'($past(ilen_i)));
  a_r5_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !vec_load_i) |=> psw_o == ($past(pop_data_i) & 8'hFB));
  a_r6_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !pop_i && !vec_load_i) |=>
      (!psw_o[7] && psw_o[6:0] == $past(psw_o[6:0])));
  a_r8_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_bank_i && !irq_ack_i && !pop_i && !vec_load_i) |=> bank_o == $past(bank_i));
  a_r10_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_o[2] == 1'b0);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(psw_o) && $stable(pc_o)));
endmodule

bind cpu_ctrl_regs cpu_ctrl_regs_chk chk_i (.*);

// File: tb/cpu_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module cpu_ctrl_regs_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vec_load_i, br_i, adv_i, pop_i, irq_ack_i, ei_i, di_i, sel_bank_i, alu_we_i;
  logic alu_zero_i, alu_ac_i, alu_cy_i;
  logic [7:0]  vec_lo_i, vec_hi_i, pop_data_i;
  logic [15:0] br_tgt_i;
  logic [2:0]  ilen_i;
  logic [1:0]  bank_i;
  logic [15:0] pc_o;
  logic [7:0]  psw_o;
  logic [1:0]  bank_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_pc;
  logic [7:0]  exp_psw;

  always #2.5 clk_i = ~clk_i;

  cpu_ctrl_regs dut_i (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {vec_load_i, br_i, adv_i, pop_i, irq_ack_i, ei_i, di_i, sel_bank_i, alu_we_i} = '0;
    {alu_zero_i, alu_ac_i, alu_cy_i} = '0;
    vec_lo_i = '0; vec_hi_i = '0; pop_data_i = '0; br_tgt_i = '0;
    ilen_i = '0; bank_i = '0;
  endtask

  // expected next state, written from the requirement list
  task automatic predict();
    if (vec_load_i) exp_pc = {vec_hi_i, vec_lo_i};
    else if (br_i)  exp_pc = br_tgt_i;
    else if (adv_i) exp_pc = exp_pc + 16'(ilen_i);
    if (vec_load_i) exp_psw = 8'h02;
    else if (pop_i) exp_psw = pop_data_i & 8'hFB;
    else if (irq_ack_i) exp_psw[7] = 1'b0;
    else if (ei_i || di_i || sel_bank_i) begin
      if (di_i) exp_psw[7] = 1'b0;
      else if (ei_i) exp_psw[7] = 1'b1;
      if (sel_bank_i) begin exp_psw[5] = bank_i[1]; exp_psw[3] = bank_i[0]; end
    end else if (alu_we_i) begin
      exp_psw[6] = alu_zero_i; exp_psw[4] = alu_ac_i; exp_psw[0] = alu_cy_i;
    end
  endtask

  // inputs set at a negedge; apply one edge, compare at the next negedge
  task automatic cycle(input string req);
    predict();
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, pc_o, exp_pc);
    check(req, {8'h00, psw_o}, {8'h00, exp_psw});
    check(req, {14'd0, bank_o}, {14'd0, exp_psw[5], exp_psw[3]});
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    exp_pc = 16'h0000; exp_psw = 8'h02;
    repeat (2) @(negedge clk_i);
    check("R1", pc_o, 16'h0000);
    check("R1", {8'h00, psw_o}, 16'h0002);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: vector loads, then vector with every other command raised
    for (int i = 0; i < 16; i++) begin
      vec_load_i = 1'b1;
      vec_lo_i = 8'(i * 37 + 5); vec_hi_i = 8'(i * 91 + 16);
      cycle("R2");
    end
    pop_i = 1; pop_data_i = 8'hFF; ei_i = 1; irq_ack_i = 1; alu_we_i = 1;
    br_i = 1; br_tgt_i = 16'h1234; adv_i = 1; ilen_i = 3'd4;
    vec_load_i = 1; vec_lo_i = 8'h34; vec_hi_i = 8'h12;
    cycle("R2");

    // R4: every instruction length, then wrap past FFFFh
    for (int l = 0; l < 8; l++) begin
      adv_i = 1; ilen_i = 3'(l); cycle("R4");
    end
    vec_load_i = 1; vec_lo_i = 8'hFE; vec_hi_i = 8'hFF; cycle("R2");
    adv_i = 1; ilen_i = 3'd3; cycle("R4");

    // R3: branch beats advance
    for (int i = 0; i < 8; i++) begin
      br_i = 1; br_tgt_i = 16'(i * 16'h2481 + 7); adv_i = 1; ilen_i = 3'd2;
      cycle("R3");
    end

    // R5 + R10: every popped byte, reserved bit dropped
    for (int v = 0; v < 256; v++) begin
      pop_i = 1; pop_data_i = 8'(v); cycle("R5");
    end
    pop_i = 1; pop_data_i = 8'h5A; irq_ack_i = 1; ei_i = 1; alu_we_i = 1; sel_bank_i = 1;
    cycle("R5");

    // R7: EI / DI, conflict
    ei_i = 1; cycle("R7");
    di_i = 1; cycle("R7");
    ei_i = 1; cycle("R7");
    ei_i = 1; di_i = 1; cycle("R7");
    ei_i = 1; cycle("R7");

    // R6: acknowledge beats explicit and ALU commands
    irq_ack_i = 1; ei_i = 1; sel_bank_i = 1; bank_i = 2'd3;
    alu_we_i = 1; alu_zero_i = 1; alu_ac_i = 1; alu_cy_i = 1;
    cycle("R6");

    // R8: every bank
    for (int b = 0; b < 4; b++) begin
      sel_bank_i = 1; bank_i = 2'(b); cycle("R8");
    end

    // R9: every ALU flag combination
    for (int f = 0; f < 8; f++) begin
      alu_we_i = 1; {alu_zero_i, alu_ac_i, alu_cy_i} = 3'(f); cycle("R9");
    end
    // R7: explicit beats ALU
    ei_i = 1; alu_we_i = 1; alu_zero_i = 1; alu_ac_i = 1; alu_cy_i = 1; cycle("R7");

    // R10: idle cycles hold
    for (int i = 0; i < 4; i++) cycle("R10");

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0; #1;
    check("R1", pc_o, 16'h0000);
    check("R1", {8'h00, psw_o}, 16'h0002);
    check("R1", {14'd0, bank_o}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule